// File: doc/BRIEF.md
# Sequential Function Chart Engine

This block runs a fixed sequential function chart in hardware. It keeps one activity flag for each step. Several steps may be active together, so the chart can hold a parallel section. The flags move only on a scan: a clock edge at which the scan strobe is high. On a scan, every transition whose preceding steps are all active is evaluated against its condition bit. All such transitions are judged on the flags as they stood before that scan. A transition that fires clears its preceding steps and sets its following steps on the same edge.

The chart has eight steps and eight transitions, wired as follows:

- Simple sequence: S0 (initial) leads through T0 to S1.
- Selective branch: from S1, T1 goes to S2 and T2 goes to S3. T1 is the left-hand branch and wins a tie.
- Selective merge: S2 through T3, or S3 through T4, reaches S4.
- Parallel fork: T5 starts S5 and S6 together.
- Parallel join: T6 needs both S5 and S6 and leads to S7.
- Backward jump: T7 returns from S7 to S0.

The action logic outside the block decodes the active-step vector to drive its outputs. It can use the enabled-transition vector to see which conditions are being watched.

Top module: `sfc_engine`

## Requirements
- R1: After the hardware reset (rst_n low), only S0 is active. A scan with chart_rst high makes only S0 active, and it takes priority over any transition that would fire on the same scan.
- R2: On a clock edge with scan_en low, step_act does not change, whatever chart_rst and trans_cond are.
- R3: trans_en bit k is high exactly when every step before transition k is active: T0←S0, T1←S1, T2←S1, T3←S2, T4←S3, T5←S4, T6←S5 and S6, T7←S7.
- R4: A scan with S0 active and trans_cond bit 0 high clears S0 and sets S1 on the same scan.
- R5: A condition bit whose transition is not enabled has no effect. When no enabled transition's condition is high, a scan leaves step_act unchanged.
- R6: With S1 active, bit 1 high moves the flag to S2. Bit 2 high with bit 1 low moves it to S3. With both bits high, only S2 becomes active.
- R7: S2 with bit 3 high, or S3 with bit 4 high, moves the flag to S4.
- R8: S4 with bit 5 high clears S4 and sets S5 and S6 together.
- R9: T6 is evaluated only while S5 and S6 are both active. When bit 6 is high, it clears both and sets S7.
- R10: S7 with bit 7 high clears S7 and sets S0.
- R11: Bit i of step_act is step Si, and bit k of trans_cond and trans_en is transition Tk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, which loads the initial step |
| scan_en | input | 1 | Scan strobe; the flags move only on edges where it is high |
| chart_rst | input | 1 | Request to return the chart to its initial step on this scan |
| trans_cond | input | 8 | Condition bit per transition |
| step_act | output | 8 | Active flag per step |
| trans_en | output | 8 | Enabled flag per transition |

## Verification
On every cycle, the assertions check the following:

- Exactly one token exists in the sequential part of the chart, with S5 and S6 always equal.
- Flags stay frozen between scans.
- A chart reset on a scan lands on S0 alone.
- The left-hand branch wins a tie.
- A join clears both parallel steps.

Other behaviours can only be shown by the bench's sweep. It checks the exact destination of each transition and the enabled-transition mapping. It also confirms that conditions of inactive transitions are ignored, by driving each reachable chart position with every condition pattern.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int N_STEP  = 8;
    localparam int N_TRANS = 8;

    typedef logic [N_STEP-1:0]  step_vec_t;
    typedef logic [N_TRANS-1:0] trans_vec_t;

    // step indices
    localparam int ST_INIT  = 0;
    localparam int ST_ARM   = 1;
    localparam int ST_LEFT  = 2;
    localparam int ST_RIGHT = 3;
    localparam int ST_MERGE = 4;
    localparam int ST_PARA  = 5;
    localparam int ST_PARB  = 6;
    localparam int ST_DONE  = 7;

    // transition indices
    localparam int TR_START = 0;
    localparam int TR_SELL  = 1;
    localparam int TR_SELR  = 2;
    localparam int TR_MRGL  = 3;
    localparam int TR_MRGR  = 4;
    localparam int TR_FORK  = 5;
    localparam int TR_JOIN  = 6;
    localparam int TR_BACK  = 7;

    localparam step_vec_t INIT_ACT = step_vec_t'(1) << ST_INIT;

    typedef struct packed {
        step_vec_t act;
    } eng_state_t;
endpackage

// File: rtl/sfc_trans_gate.sv
module sfc_trans_gate
    import sfc_pkg::*;
(
    input  step_vec_t  act,
    input  trans_vec_t cond,
    output trans_vec_t en,
    output trans_vec_t fire
);
    always_comb begin
        en           = '0;
        en[TR_START] = act[ST_INIT];
        en[TR_SELL]  = act[ST_ARM];
        en[TR_SELR]  = act[ST_ARM];
        en[TR_MRGL]  = act[ST_LEFT];
        en[TR_MRGR]  = act[ST_RIGHT];
        en[TR_FORK]  = act[ST_MERGE];
        en[TR_JOIN]  = act[ST_PARA] & act[ST_PARB];
        en[TR_BACK]  = act[ST_DONE];
    end

    always_comb begin
        fire = en & cond;
        // selective divergence: left-hand branch has priority
        fire[TR_SELR] = en[TR_SELR] & cond[TR_SELR] & ~cond[TR_SELL];
    end
endmodule

// File: rtl/sfc_step_update.sv
module sfc_step_update
    import sfc_pkg::*;
(
    input  step_vec_t  act,
    input  trans_vec_t fire,
    output step_vec_t  nxt
);
    step_vec_t leave;
    step_vec_t enter;

    always_comb begin
        leave = '0;
        enter = '0;
        leave[ST_INIT]  = fire[TR_START];
        leave[ST_ARM]   = fire[TR_SELL] | fire[TR_SELR];
        leave[ST_LEFT]  = fire[TR_MRGL];
        leave[ST_RIGHT] = fire[TR_MRGR];
        leave[ST_MERGE] = fire[TR_FORK];
        leave[ST_PARA]  = fire[TR_JOIN];
        leave[ST_PARB]  = fire[TR_JOIN];
        leave[ST_DONE]  = fire[TR_BACK];

        enter[ST_INIT]  = fire[TR_BACK];
        enter[ST_ARM]   = fire[TR_START];
        enter[ST_LEFT]  = fire[TR_SELL];
        enter[ST_RIGHT] = fire[TR_SELR];
        enter[ST_MERGE] = fire[TR_MRGL] | fire[TR_MRGR];
        enter[ST_PARA]  = fire[TR_FORK];
        enter[ST_PARB]  = fire[TR_FORK];
        enter[ST_DONE]  = fire[TR_JOIN];
    end

    for (genvar i = 0; i < N_STEP; i++) begin : g_step
        assign nxt[i] = (act[i] & ~leave[i]) | enter[i];
    end
endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
    import sfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scan_en,
    input  logic       chart_rst,
    input  logic [7:0] trans_cond,
    output logic [7:0] step_act,
    output logic [7:0] trans_en
);
    eng_state_t st_d, st_q;
    trans_vec_t en_w, fire_w;
    step_vec_t  evolve_w;

    sfc_trans_gate u_gate (
        .act  (st_q.act),
        .cond (trans_cond),
        .en   (en_w),
        .fire (fire_w)
    );

    sfc_step_update u_upd (
        .act  (st_q.act),
        .fire (fire_w),
        .nxt  (evolve_w)
    );

    always_comb begin
        st_d = st_q;
        if (scan_en) begin
            if (chart_rst) st_d.act = INIT_ACT;
            else           st_d.act = evolve_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.act <= INIT_ACT;
        else        st_q     <= st_d;
    end

    assign step_act = st_q.act;
    assign trans_en = en_w;

    // sequential part holds exactly one token (parallel pair counted once)
    p_one_token_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({step_act[7], step_act[5:0]}) == 1);
    p_pair_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_act[ST_PARA] == step_act[ST_PARB]);
    p_hold_noscan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> $stable(step_act));
    p_chart_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && chart_rst) |=> step_act == INIT_ACT);
    p_leftmost_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !chart_rst && step_act[ST_ARM] && trans_cond[1] && trans_cond[2])
        |=> step_act[ST_LEFT] && !step_act[ST_RIGHT]);
    p_join_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !chart_rst && trans_en[TR_JOIN] && trans_cond[6])
        |=> step_act[ST_DONE] && !step_act[ST_PARA] && !step_act[ST_PARB]);
endmodule

// File: tb/sfc_engine_tb.sv
module sfc_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_en = 1'b0;
    logic       chart_rst = 1'b0;
    logic [7:0] trans_cond = '0;
    logic [7:0] step_act;
    logic [7:0] trans_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sfc_engine u_dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .chart_rst(chart_rst),
        .trans_cond(trans_cond), .step_act(step_act), .trans_en(trans_en)
    );

    // chart positions: 0 S0, 1 S1, 2 S2, 3 S3, 4 S4, 5 S5+S6, 6 S7
    function automatic logic [7:0] pos_steps(int p);
        case (p)
            0: return 8'h01; 1: return 8'h02; 2: return 8'h04; 3: return 8'h08;
            4: return 8'h10; 5: return 8'h60; default: return 8'h80;
        endcase
    endfunction

    function automatic logic [7:0] pos_en(int p);
        case (p)
            0: return 8'h01; 1: return 8'h06; 2: return 8'h08; 3: return 8'h10;
            4: return 8'h20; 5: return 8'h40; default: return 8'h80;
        endcase
    endfunction

    function automatic int pos_next(int p, logic [7:0] c);
        case (p)
            0: return c[0] ? 1 : 0;
            1: return c[1] ? 2 : (c[2] ? 3 : 1);
            2: return c[3] ? 4 : 2;
            3: return c[4] ? 4 : 3;
            4: return c[5] ? 5 : 4;
            5: return c[6] ? 6 : 5;
            default: return c[7] ? 0 : 6;
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_scan(logic rq, logic [7:0] c);
        @(negedge clk);
        scan_en = 1'b1; chart_rst = rq; trans_cond = c;
        @(negedge clk);
        scan_en = 1'b0; chart_rst = 1'b0; trans_cond = '0;
    endtask

    task automatic go_to(int p);
        do_scan(1'b1, 8'h00);
        if (p >= 1) do_scan(1'b0, 8'h01);
        if (p == 3) do_scan(1'b0, 8'h04);
        else if (p >= 2) do_scan(1'b0, 8'h02);
        if (p >= 4) do_scan(1'b0, 8'h08);
        if (p >= 5) do_scan(1'b0, 8'h20);
        if (p >= 6) do_scan(1'b0, 8'h40);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state R11", step_act, 8'h01);
        check("R3 reset enables", trans_en, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle after reset", step_act, 8'h01);
        for (int p = 0; p < 7; p++) begin
            for (int c = 0; c < 256; c++) begin
                for (int m = 0; m < 3; m++) begin
                    int np;
                    string tag;
                    go_to(p);
                    check("R3 enabled vector", trans_en, pos_en(p));
                    @(negedge clk);
                    trans_cond = c[7:0];
                    if (m == 0) begin
                        scan_en = 1'b1; chart_rst = 1'b0;
                        np = pos_next(p, c[7:0]);
                        if (np == p)      tag = "R5 no fire";
                        else if (p == 0)  tag = "R4 sequence";
                        else if (p == 1)  tag = "R6 selective";
                        else if (p <= 3)  tag = "R7 merge";
                        else if (p == 4)  tag = "R8 fork";
                        else if (p == 5)  tag = "R9 join";
                        else              tag = "R10 jump back";
                    end else if (m == 1) begin
                        scan_en = 1'b1; chart_rst = 1'b1;
                        np = 0; tag = "R1 chart reset";
                    end else begin
                        scan_en = 1'b0; chart_rst = c[0];
                        np = p; tag = "R2 no scan";
                    end
                    @(negedge clk);
                    scan_en = 1'b0; chart_rst = 1'b0; trans_cond = '0;
                    check(tag, step_act, pos_steps(np));
                end
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule